// File: doc/BRIEF.md
# Occupancy-Priority Output Port Arbiter

This block decides which of the five input ports of a mesh router may move a flit into one output port in a given cycle. Each input says whether it wants this output and how full its input buffer is. The arbiter serves the most heavily loaded requester first. A rotating pointer breaks ties between inputs with equal occupancy. A consecutive-win cap stops one busy input from holding the output forever while lighter inputs are waiting.

The arbiter also keeps the fill count of the output buffer. Each grant writes one flit into that buffer, and each drain pulse from the link side removes one. A grant is issued only while the buffer has a free slot. The count is exported so the partition's route controller can read it as a congestion measure.

The grant is combinational from the current requests, occupancies and registered history. The win history and the buffer count update on the following clock edge.

Top module: `occ_port_arbiter`

## Requirements
- R1: No grant is issued in a cycle where the exported output-buffer count equals OUT_DEPTH (default 8). A drain in the same cycle does not free a slot until the next cycle.
- R2: `gnt_o` is one-hot or zero. It only selects a requesting input, and `gnt_valid_o` is high exactly when `gnt_o` is non-zero. With no request asserted there is no grant.
- R3: Among the eligible requesters, the grant goes to the input with the largest occupancy value. Input i's occupancy is `in_occ_i[i*OCC_W +: OCC_W]`, read as an unsigned number.
- R4: Among eligible requesters that share the largest occupancy, the winner is the first one met when scanning upward with wrap-around. The scan starts at the input after the last winner, and at input 0 when nothing has won since reset.
- R5: An input that has won WIN_CAP (default 4) grants in a row is not granted while any other input requests. Cycles without a grant do not break a run.
- R6: An input at the cap that is the only requester is granted again, and its run count stays at WIN_CAP.
- R7: When a different input wins, the run count restarts at one for the new winner. A previously capped input may then win WIN_CAP times in a row again.
- R8: The output-buffer count rises by one on each grant. It falls by one on each cycle with `out_drain_i` high while the count is non-zero. Both happening together leave it unchanged. It never exceeds OUT_DEPTH.
- R9: After reset the count is zero, there is no win history, and the first tie goes to input 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_IN | Per-input request for this output |
| in_occ_i | input | N_IN*OCC_W | Per-input buffer occupancy, input i at bits i*OCC_W upward |
| out_drain_i | input | 1 | One flit leaves the output buffer this cycle |
| gnt_o | output | N_IN | One-hot grant |
| gnt_valid_o | output | 1 | A grant is issued this cycle |
| out_occ_o | output | $clog2(OUT_DEPTH+1) | Output-buffer fill count |

## Verification
The grant is due in the same cycle as the request and occupancy values that produce it. The bench drives inputs just after a falling edge and samples `gnt_o` and `gnt_valid_o` one nanosecond later, before the next rising edge. The fill count and the win history take effect one rising edge after the grant or drain that changes them. The bench therefore advances its own model at each rising edge and compares `out_occ_o` in the next sampling window. Directed phases cover the priority, tie, cap, sole-requester and full-buffer corners, and a long pseudo-random sweep follows them.

// File: rtl/occ_arb_pkg.sv
package occ_arb_pkg;
  // index of the port following cur on a ring of n ports
  function automatic int unsigned ring_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/occ_arb_streak.sv
module occ_arb_streak #(
  parameter int N_IN    = 5,
  parameter int WIN_CAP = 4,
  localparam int IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int SW     = $clog2(WIN_CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_en_i,
  input  logic [IDX_W-1:0] win_idx_i,
  output logic [IDX_W-1:0] last_idx_o,
  output logic             have_last_o,
  output logic             capped_o
);
  logic [IDX_W-1:0] last_q, last_d;
  logic             have_q, have_d;
  logic [SW-1:0]    run_q, run_d;
  logic             same_w;

  assign same_w = have_q && (win_idx_i == last_q);

  always_comb begin
    last_d = last_q;
    have_d = have_q;
    run_d  = run_q;
    if (win_en_i) begin
      have_d = 1'b1;
      last_d = win_idx_i;
      if (same_w) run_d = (run_q >= SW'(WIN_CAP)) ? SW'(WIN_CAP) : run_q + SW'(1);
      else        run_d = SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      have_q <= 1'b0;
      run_q  <= '0;
    end else if (win_en_i) begin
      last_q <= last_d;
      have_q <= have_d;
      run_q  <= run_d;
    end
  end

  assign last_idx_o  = last_q;
  assign have_last_o = have_q;
  assign capped_o    = have_q && (run_q >= SW'(WIN_CAP));

  assert_run_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en_i && have_q && (win_idx_i != last_q)) |=> (run_q == SW'(1)));

  assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= SW'(WIN_CAP));
endmodule

// File: rtl/occ_arb_mask.sv
module occ_arb_mask #(
  parameter int N_IN   = 5,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0]  req_i,
  input  logic             slot_free_i,
  input  logic [IDX_W-1:0] last_idx_i,
  input  logic             capped_i,
  output logic [N_IN-1:0]  elig_o
);
  logic [N_IN-1:0] last_oh;
  logic [N_IN-1:0] others;

  always_comb begin
    last_oh = '0;
    last_oh[last_idx_i] = 1'b1;
  end

  assign others = req_i & ~last_oh;

  always_comb begin
    if (!slot_free_i)               elig_o = '0;
    else if (capped_i && |others)   elig_o = others;
    else                            elig_o = req_i;
  end
endmodule

// File: rtl/occ_arb_pick.sv
module occ_arb_pick #(
  parameter int N_IN   = 5,
  parameter int OCC_W  = 4,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0]       elig_i,
  input  logic [N_IN*OCC_W-1:0] occ_i,
  input  logic [IDX_W-1:0]      ptr_i,
  output logic [N_IN-1:0]       gnt_o,
  output logic                  valid_o,
  output logic [IDX_W-1:0]      idx_o
);
  logic             found;
  logic [OCC_W-1:0] best;
  int               j;

  always_comb begin
    found = 1'b0;
    best  = '0;
    idx_o = '0;
    j     = 0;
    for (int k = 0; k < N_IN; k++) begin
      j = (int'(ptr_i) + k) % N_IN;
      if (elig_i[j] && (!found || (occ_i[j*OCC_W +: OCC_W] > best))) begin
        found = 1'b1;
        best  = occ_i[j*OCC_W +: OCC_W];
        idx_o = IDX_W'(j);
      end
    end
    gnt_o = '0;
    if (found) gnt_o[idx_o] = 1'b1;
    valid_o = found;
  end
endmodule

// File: rtl/occ_arb_outcnt.sv
module occ_arb_outcnt #(
  parameter int OUT_DEPTH = 8,
  localparam int CW       = $clog2(OUT_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          drain_i,
  output logic [CW-1:0] occ_o,
  output logic          free_o
);
  logic [CW-1:0] occ_q, occ_d;
  logic          pop_w;
  logic          upd_w;

  assign pop_w = drain_i && (occ_q != '0);
  assign upd_w = push_i ^ pop_w;

  always_comb begin
    occ_d = occ_q;
    if (push_i && !pop_w)      occ_d = occ_q + CW'(1);
    else if (pop_w && !push_i) occ_d = occ_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     occ_q <= '0;
    else if (upd_w) occ_q <= occ_d;
  end

  assign occ_o  = occ_q;
  assign free_o = occ_q < CW'(OUT_DEPTH);

  assert_occ_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (occ_q == $past(occ_q) + CW'($past(push_i)) - CW'($past(pop_w))));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CW'(OUT_DEPTH));
endmodule

// File: rtl/occ_port_arbiter.sv
module occ_port_arbiter #(
  parameter int N_IN      = 5,
  parameter int OCC_W     = 4,
  parameter int OUT_DEPTH = 8,
  parameter int WIN_CAP   = 4,
  localparam int IDX_W    = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int CW       = $clog2(OUT_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IN-1:0]       req_i,
  input  logic [N_IN*OCC_W-1:0] in_occ_i,
  input  logic                  out_drain_i,
  output logic [N_IN-1:0]       gnt_o,
  output logic                  gnt_valid_o,
  output logic [CW-1:0]         out_occ_o
);
  import occ_arb_pkg::*;

  logic [IDX_W-1:0] last_idx, ptr, win_idx;
  logic             have_last, capped, slot_free;
  logic [N_IN-1:0]  elig, last_oh;

  assign ptr = have_last ? IDX_W'(ring_next(32'(last_idx), N_IN)) : '0;

  occ_arb_outcnt #(.OUT_DEPTH(OUT_DEPTH)) u_outcnt (
    .clk(clk), .rst_n(rst_n), .push_i(gnt_valid_o), .drain_i(out_drain_i),
    .occ_o(out_occ_o), .free_o(slot_free)
  );

  occ_arb_mask #(.N_IN(N_IN)) u_mask (
    .req_i(req_i), .slot_free_i(slot_free), .last_idx_i(last_idx),
    .capped_i(capped), .elig_o(elig)
  );

  occ_arb_pick #(.N_IN(N_IN), .OCC_W(OCC_W)) u_pick (
    .elig_i(elig), .occ_i(in_occ_i), .ptr_i(ptr),
    .gnt_o(gnt_o), .valid_o(gnt_valid_o), .idx_o(win_idx)
  );

  occ_arb_streak #(.N_IN(N_IN), .WIN_CAP(WIN_CAP)) u_streak (
    .clk(clk), .rst_n(rst_n), .win_en_i(gnt_valid_o), .win_idx_i(win_idx),
    .last_idx_o(last_idx), .have_last_o(have_last), .capped_o(capped)
  );

  always_comb begin
    last_oh = '0;
    last_oh[last_idx] = 1'b1;
  end

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0) && (gnt_valid_o == (gnt_o != '0)));

  assert_full_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_occ_o == CW'(OUT_DEPTH)) |-> !gnt_valid_o);

  assert_cap_yield_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (capped && ((req_i & ~last_oh) != '0)) |-> ((gnt_o & last_oh) == '0));

  assert_sole_regrant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (have_last && (req_i == last_oh) && (out_occ_o < CW'(OUT_DEPTH))) |-> (gnt_o == last_oh));
endmodule

// File: tb/occ_port_arbiter_bench.sv
module occ_port_arbiter_bench;
  localparam int N = 5, W = 4, D = 8, CAP = 4, CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0][W-1:0] occ_arr = '0;
  logic drain = 1'b0;
  logic [N-1:0] gnt;
  logic gv;
  logic [CW-1:0] oocc;

  always #5 clk = ~clk;

  occ_port_arbiter u_occ_port_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .in_occ_i(occ_arr),
    .out_drain_i(drain), .gnt_o(gnt), .gnt_valid_o(gv), .out_occ_o(oocc)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_last = 0, m_run = 0, m_occ = 0;
  bit m_have = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: inputs already set; compare, then advance model at the rising edge
  task automatic step(string tag);
    logic [N-1:0] cand, others, egnt;
    int maxv, ptr, win;
    #1;
    others = req & ~(N'(1) << m_last);
    cand = (m_have && m_run >= CAP && others != 0) ? others : req;
    if (m_occ >= D) cand = '0;
    maxv = -1;
    for (int i = 0; i < N; i++) if (cand[i] && int'(occ_arr[i]) > maxv) maxv = int'(occ_arr[i]);
    ptr = m_have ? (m_last + 1) % N : 0;
    win = -1;
    for (int k = 0; k < N; k++) begin
      int j = (ptr + k) % N;
      if (win < 0 && cand[j] && int'(occ_arr[j]) == maxv) win = j;
    end
    egnt = (win >= 0) ? (N'(1) << win) : '0;
    check({tag, " grant"}, int'(gnt), int'(egnt));
    check({tag, " valid R2"}, int'(gv), (win >= 0) ? 1 : 0);
    check({tag, " out count R8"}, int'(oocc), m_occ);
    @(posedge clk);
    if (win >= 0) begin
      if (m_have && win == m_last) m_run = (m_run < CAP) ? m_run + 1 : CAP;
      else m_run = 1;
      m_last = win; m_have = 1;
    end
    if (win >= 0 && !(drain && m_occ > 0)) m_occ++;
    else if (win < 0 && drain && m_occ > 0) m_occ--;
    @(negedge clk);
  endtask

  task automatic set_occ(int a, int b, int c, int d, int e);
    occ_arr[0] = W'(a); occ_arr[1] = W'(b); occ_arr[2] = W'(c);
    occ_arr[3] = W'(d); occ_arr[4] = W'(e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, nothing requested
    step("R9 reset idle");
    // R4/R9: first tie after reset goes to input 0, then rotates
    req = 5'b11111; drain = 1'b1; set_occ(3, 3, 3, 3, 3);
    step("R9 first tie"); step("R4 tie rotate"); step("R4 tie rotate2");
    // R3: highest occupancy wins
    set_occ(1, 9, 4, 2, 7); step("R3 max occ");
    set_occ(15, 0, 14, 3, 2); step("R3 max occ b");
    // R5/R7: heavy input 2 vs light input 0
    req = 5'b00101; set_occ(1, 0, 12, 0, 0);
    for (int i = 0; i < 10; i++) step("R5 cap yield");
    step("R7 restart run");
    // R6: sole requester at cap
    req = 5'b01000;
    for (int i = 0; i < 7; i++) step("R6 sole requester");
    // R1: fill the output buffer without draining
    drain = 1'b0; req = 5'b10010; set_occ(0, 5, 0, 0, 5);
    for (int i = 0; i < 11; i++) step("R1 full block");
    drain = 1'b1; req = '0;
    for (int i = 0; i < 10; i++) step("R8 drain down");
    // R2: no request, no grant
    step("R2 no request");
    // mixed sweep
    for (int c = 0; c < 4000; c++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      req = seed[4:0] & {5{seed[31] | seed[30]}};
      for (int i = 0; i < N; i++) occ_arr[i] = W'(seed[8 + i*3 +: 2]) | W'({seed[27], 2'b00});
      drain = seed[29] & seed[28];
      step("R3 R4 R5 sweep");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule